// File: doc/BRIEF.md
# Power Management Event Register Bank

This block holds the power-management status, enable and control registers of a chipset behind a 64-byte I/O window. Software reaches every register one byte at a time through a byte-wide read/write strobe and a 6-bit offset; 16-bit registers span two consecutive offsets and 32-bit registers span four. The low-numbered offset always holds the least significant byte.

Status registers latch hardware events from the event inputs. The timer overflow input is one of these events. Software clears status bits by writing ones. Enable and control registers only keep the bits their fixed masks allow. A summary byte is built from the state of the other status registers, and the interrupt enable state decides when a level system control interrupt is raised. That interrupt leaves on either a PCI INTx line or legacy IRQ 9. A write to the control register that leaves the sleep-enable bit set raises a one-cycle suspend request that carries a 3-bit sleep type. The actual power-off and reset actions belong to other logic.

Top module: `pm_event_regs`

## Requirements
- R1: Offsets 0x00 PM status, 0x02 PM enable, 0x04 PM control, 0x0C GP status, 0x0E GP enable, 0x18 global status, 0x20 global enable (16-bit), and 0x1C device status, 0x28 global control, 0x2C device control (32-bit) are mapped. Offset base+n addresses bits 8n+7:8n. Any other offset reads 0x00, and writes to it change no register.
- R2: PM status resets to 0x0100 and keeps only bits in mask 0x8D31. A write clears the masked bits written as one. Bits in pm_evt_i set bits in the mask. When a set and a clear land in the same cycle, the set wins.
- R3: Writable registers reset to zero and keep only their mask bits: PM enable 0x0521, PM control 0x3C07, GP enable 0x0F01, global enable 0x8D1F, global control 0x0700FF07, device control 0x0FFFFFFF. A byte write changes only its own lane.
- R4: GP status (mask 0x0F81), global status (mask 0x0DF7) and device status (mask 0x3FFF0FFF) reset to zero. They are set from gp_evt_i, glb_evt_i and dev_evt_i within their masks and are cleared by writing ones, with set winning.
- R5: Device status always reads with bit 28 equal to one.
- R6: Reading offset 0x18 returns the stored global status bits ANDed with 0x05, plus these summary bits:
  - bit 7 when GP status is nonzero
  - bit 6 when PM status is nonzero
  - bit 5 when smm_i is high
  - bit 4 when device status is nonzero

  Offset 0x19 returns stored bits 15:8.
- R7: One cycle after (PM status AND PM enable AND 0x0521) becomes nonzero, the interrupt is active. One cycle after that term becomes zero, the interrupt is inactive.
- R8: With irq_route_i high the interrupt drives intx_o and irq9_o stays low. With irq_route_i low it drives irq9_o and intx_o stays low.
- R9: A tmr_ovf_i pulse sets PM status bit 0 at that clock edge. The interrupt follows one cycle later if enabled.
- R10: In the cycle after any write to offset 0x04 or 0x05 that leaves PM control bit 13 set, susp_req_o is high for one cycle. During that cycle susp_type_o equals control bits 12:10, where 0 means soft off and 1 means suspend to RAM.
- R11: rdata_o is 0x00 whenever rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 6 | Byte offset in the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| pm_evt_i | input | 16 | PM status set events |
| gp_evt_i | input | 16 | GP status set events |
| glb_evt_i | input | 16 | Global status set events |
| dev_evt_i | input | 32 | Device status set events |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| smm_i | input | 1 | System management mode active |
| irq_route_i | input | 1 | 1 routes the interrupt to INTx, 0 to IRQ 9 |
| intx_o | output | 1 | PCI INTx level |
| irq9_o | output | 1 | Legacy IRQ 9 level |
| susp_req_o | output | 1 | Suspend request pulse |
| susp_type_o | output | 3 | Requested sleep type |

## Verification
The hardest case to reach is a status event and a write-one-to-clear of the same bit landing on one clock edge while the matching enable is set. That case decides both the stored bit and the interrupt level one cycle later. Random cycles therefore inject sparse event bits on every status register while random writes land on the same offsets. Over a few hundred cycles these collisions happen many times. Directed sequences add the overflow-to-interrupt path in both routings and suspend writes of type 0 and type 1.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
  localparam int AW = 6;
  localparam int DW = 8;

  localparam logic [AW-1:0] OFS_PM_STS  = 6'h00;
  localparam logic [AW-1:0] OFS_PM_EN   = 6'h02;
  localparam logic [AW-1:0] OFS_PM_CTL  = 6'h04;
  localparam logic [AW-1:0] OFS_GP_STS  = 6'h0C;
  localparam logic [AW-1:0] OFS_GP_EN   = 6'h0E;
  localparam logic [AW-1:0] OFS_GLB_STS = 6'h18;
  localparam logic [AW-1:0] OFS_DEV_STS = 6'h1C;
  localparam logic [AW-1:0] OFS_GLB_EN  = 6'h20;
  localparam logic [AW-1:0] OFS_GLB_CTL = 6'h28;
  localparam logic [AW-1:0] OFS_DEV_CTL = 6'h2C;

  localparam logic [15:0] PM_STS_MASK  = 16'h8D31;
  localparam logic [15:0] PM_STS_RST   = 16'h0100;
  localparam logic [15:0] PM_EN_MASK   = 16'h0521;
  localparam logic [15:0] PM_CTL_MASK  = 16'h3C07;
  localparam logic [15:0] GP_STS_MASK  = 16'h0F81;
  localparam logic [15:0] GP_EN_MASK   = 16'h0F01;
  localparam logic [15:0] GLB_STS_MASK = 16'h0DF7;
  localparam logic [15:0] GLB_EN_MASK  = 16'h8D1F;
  localparam logic [31:0] DEV_STS_MASK = 32'h3FFF0FFF;
  localparam logic [31:0] GLB_CTL_MASK = 32'h0700FF07;
  localparam logic [31:0] DEV_CTL_MASK = 32'h0FFFFFFF;

  localparam logic [15:0] SCI_EVT_MASK = 16'h0521;
  localparam logic [31:0] DEV_STS_FORCE = 32'h1000_0000;
  localparam int SLP_EN_BIT = 13;
  localparam int SLP_TYP_LSB = 10;
endpackage

// File: rtl/pm_w1c_reg.sv
module pm_w1c_reg #(
  parameter int          W    = 16,
  parameter logic [5:0]  BASE = 6'h00,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [5:0]   addr_i,
  input  logic [7:0]   wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  localparam int LANES = W / 8;
  localparam int LB    = $clog2(LANES);

  logic         hit;
  logic [W-1:0] clr;

  assign hit = wr_en_i && (addr_i[5:LB] == BASE[5:LB]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign clr[g*8 +: 8] = (hit && addr_i[LB-1:0] == LB'(g)) ? wdata_i : 8'h00;
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST & MASK;
    else         q_o <= (q_o & ~(clr & MASK)) | (set_i & MASK);
  end
endmodule

// File: rtl/pm_rw_reg.sv
module pm_rw_reg #(
  parameter int           W    = 16,
  parameter logic [5:0]   BASE = 6'h00,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [5:0]   addr_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] q_o
);
  localparam int LANES = W / 8;
  localparam int LB    = $clog2(LANES);

  logic hit;
  assign hit = wr_en_i && (addr_i[5:LB] == BASE[5:LB]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q_o[g*8 +: 8] <= 8'h00;
      else if (hit && addr_i[LB-1:0] == LB'(g))
        q_o[g*8 +: 8] <= wdata_i & MASK[g*8 +: 8];
    end
  end
endmodule

// File: rtl/pm_sci_route.sv
module pm_sci_route #(
  parameter logic [15:0] EVT_MASK = 16'h0521
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] sts_i,
  input  logic [15:0] en_i,
  input  logic        route_i,
  output logic        intx_o,
  output logic        irq9_o
);
  logic sci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= |(sts_i & en_i & EVT_MASK);
  end

  assign intx_o = sci_q &  route_i;
  assign irq9_o = sci_q & ~route_i;
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [5:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [15:0] pm_evt_i,
  input  logic [15:0] gp_evt_i,
  input  logic [15:0] glb_evt_i,
  input  logic [31:0] dev_evt_i,
  input  logic        tmr_ovf_i,
  input  logic        smm_i,
  input  logic        irq_route_i,
  output logic        intx_o,
  output logic        irq9_o,
  output logic        susp_req_o,
  output logic [2:0]  susp_type_o
);
  logic [15:0] pm_sts, pm_en, pm_ctl, gp_sts, gp_en, glb_sts, glb_en;
  logic [31:0] dev_sts, glb_ctl, dev_ctl;
  logic [15:0] pm_set;
  logic        ctl_wr_q;

  assign pm_set = pm_evt_i | {15'h0, tmr_ovf_i};

  pm_w1c_reg #(.W(16), .BASE(OFS_PM_STS), .MASK(PM_STS_MASK), .RST(PM_STS_RST)) u_pm_sts (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .set_i(pm_set), .q_o(pm_sts));
  pm_w1c_reg #(.W(16), .BASE(OFS_GP_STS), .MASK(GP_STS_MASK), .RST(16'h0)) u_gp_sts (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .set_i(gp_evt_i), .q_o(gp_sts));
  pm_w1c_reg #(.W(16), .BASE(OFS_GLB_STS), .MASK(GLB_STS_MASK), .RST(16'h0)) u_glb_sts (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .set_i(glb_evt_i), .q_o(glb_sts));
  pm_w1c_reg #(.W(32), .BASE(OFS_DEV_STS), .MASK(DEV_STS_MASK), .RST(32'h0)) u_dev_sts (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .set_i(dev_evt_i), .q_o(dev_sts));

  pm_rw_reg #(.W(16), .BASE(OFS_PM_EN),   .MASK(PM_EN_MASK))   u_pm_en (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(pm_en));
  pm_rw_reg #(.W(16), .BASE(OFS_PM_CTL),  .MASK(PM_CTL_MASK))  u_pm_ctl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(pm_ctl));
  pm_rw_reg #(.W(16), .BASE(OFS_GP_EN),   .MASK(GP_EN_MASK))   u_gp_en (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(gp_en));
  pm_rw_reg #(.W(16), .BASE(OFS_GLB_EN),  .MASK(GLB_EN_MASK))  u_glb_en (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(glb_en));
  pm_rw_reg #(.W(32), .BASE(OFS_GLB_CTL), .MASK(GLB_CTL_MASK)) u_glb_ctl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(glb_ctl));
  pm_rw_reg #(.W(32), .BASE(OFS_DEV_CTL), .MASK(DEV_CTL_MASK)) u_dev_ctl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .q_o(dev_ctl));

  pm_sci_route #(.EVT_MASK(SCI_EVT_MASK)) u_sci (
    .clk_i, .rst_ni, .sts_i(pm_sts), .en_i(pm_en), .route_i(irq_route_i),
    .intx_o, .irq9_o);

  // suspend: flag the control write, then sample the stored control value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_wr_q <= 1'b0;
    else         ctl_wr_q <= wr_en_i && (addr_i[5:1] == OFS_PM_CTL[5:1]);
  end
  assign susp_req_o  = ctl_wr_q & pm_ctl[SLP_EN_BIT];
  assign susp_type_o = pm_ctl[SLP_TYP_LSB +: 3];

  // read path
  logic [7:0]  glb_sum;
  logic [31:0] rd_word;

  always_comb begin
    glb_sum    = glb_sts[7:0] & 8'h05;
    glb_sum[7] = |gp_sts;
    glb_sum[6] = |pm_sts;
    glb_sum[5] = smm_i;
    glb_sum[4] = |dev_sts;
  end

  always_comb begin
    unique case (addr_i[5:2])
      4'h0:    rd_word = {pm_en, pm_sts};
      4'h1:    rd_word = {16'h0, pm_ctl};
      4'h3:    rd_word = {gp_en, gp_sts};
      4'h6:    rd_word = {16'h0, glb_sts[15:8], glb_sum};
      4'h7:    rd_word = dev_sts | DEV_STS_FORCE;
      4'h8:    rd_word = {16'h0, glb_en};
      4'hA:    rd_word = glb_ctl;
      4'hB:    rd_word = dev_ctl;
      default: rd_word = 32'h0;
    endcase
  end

  assign rdata_o = rd_en_i ? rd_word[{addr_i[1:0], 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk
  import pm_regs_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [5:0]  addr_i,
  input logic        tmr_ovf_i,
  input logic        irq_route_i,
  input logic        intx_o,
  input logic        irq9_o,
  input logic        susp_req_o,
  input logic [15:0] pm_sts,
  input logic [15:0] pm_en
);
  // R2
  pm_sts_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_sts & ~PM_STS_MASK) == 16'h0);

  // R7
  sci_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pm_sts & pm_en & SCI_EVT_MASK)) |=> (intx_o || irq9_o));

  // R7
  sci_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pm_sts & pm_en & SCI_EVT_MASK)) |=> !(intx_o || irq9_o));

  // R8
  route_intx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_route_i |-> !irq9_o);

  // R8
  route_irq9_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_route_i |-> !intx_o);

  // R9
  tmr_ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> pm_sts[0]);

  // R10
  susp_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req_o |-> ($past(wr_en_i) && $past(addr_i[5:1]) == OFS_PM_CTL[5:1]));
endmodule

bind pm_event_regs pm_event_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .tmr_ovf_i(tmr_ovf_i), .irq_route_i(irq_route_i), .intx_o(intx_o),
  .irq9_o(irq9_o), .susp_req_o(susp_req_o), .pm_sts(pm_sts), .pm_en(pm_en));

// File: tb/pm_event_regs_bench.sv
`timescale 1ns/1ps
module pm_event_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata;
  logic [15:0] pm_ev = '0, gp_ev = '0, glb_ev = '0;
  logic [31:0] dev_ev = '0;
  logic        ovf = 1'b0, smm = 1'b0, route = 1'b0;
  logic        intx, irq9, sreq;
  logic [2:0]  stype;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_pm_sts, m_pm_en, m_pm_ctl, m_gp_sts, m_gp_en, m_glb_sts, m_glb_en;
  logic [31:0] m_dev_sts, m_glb_ctl, m_dev_ctl;
  logic        m_sci, m_susp;

  always #4 clk = ~clk;

  pm_event_regs u_pm_event_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .rd_en_i(re), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .pm_evt_i(pm_ev), .gp_evt_i(gp_ev),
    .glb_evt_i(glb_ev), .dev_evt_i(dev_ev), .tmr_ovf_i(ovf), .smm_i(smm),
    .irq_route_i(route), .intx_o(intx), .irq9_o(irq9), .susp_req_o(sreq),
    .susp_type_o(stype));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h addr=%h t=%0t", tag, act, exp, addr, $time);
    end
  endtask

  function automatic bit lhit(input logic [5:0] base, input int nl);
    return we && ((addr & ~6'(nl-1)) == base);
  endfunction
  function automatic logic [31:0] lbits(input logic [5:0] base, input int nl);
    if (!lhit(base, nl)) return 32'h0;
    return 32'(wd) << (8 * int'(addr & 6'(nl-1)));
  endfunction
  function automatic logic [31:0] lmsk(input logic [5:0] base, input int nl);
    if (!lhit(base, nl)) return 32'h0;
    return 32'hFF << (8 * int'(addr & 6'(nl-1)));
  endfunction
  function automatic logic [31:0] rw(input logic [31:0] old, input logic [31:0] m,
                                     input logic [5:0] base, input int nl);
    return (old & ~lmsk(base, nl)) | (lbits(base, nl) & m);
  endfunction
  function automatic logic [31:0] w1c(input logic [31:0] old, input logic [31:0] m,
                                      input logic [5:0] base, input int nl,
                                      input logic [31:0] ev);
    return (old & ~(lbits(base, nl) & m)) | (ev & m);
  endfunction

  function automatic logic [7:0] mread(input logic [5:0] a);
    logic [31:0] w;
    logic [7:0] gs;
    gs = m_glb_sts[7:0] & 8'h05;
    gs[7] = |m_gp_sts; gs[6] = |m_pm_sts; gs[5] = smm; gs[4] = |m_dev_sts;
    case (a[5:2])
      4'h0: w = {m_pm_en, m_pm_sts};
      4'h1: w = {16'h0, m_pm_ctl};
      4'h3: w = {m_gp_en, m_gp_sts};
      4'h6: w = {16'h0, m_glb_sts[15:8], gs};
      4'h7: w = m_dev_sts | 32'h1000_0000;
      4'h8: w = {16'h0, m_glb_en};
      4'hA: w = m_glb_ctl;
      4'hB: w = m_dev_ctl;
      default: w = 32'h0;
    endcase
    return w[8*int'(a[1:0]) +: 8];
  endfunction

  function automatic string rtag(input logic [5:0] a);
    case (a[5:1])
      5'h00: return "R2";
      5'h01, 5'h02, 5'h07, 5'h10, 5'h14, 5'h15, 5'h16, 5'h17: return "R3";
      5'h06, 5'h0C: return "R4";
      5'h0E, 5'h0F: return "R5";
      5'h0D: return "R4";
      default: return "R1";
    endcase
  endfunction
  function automatic string rtag_full(input logic [5:0] a);
    if (a == 6'h18) return "R6";
    return rtag(a);
  endfunction

  task automatic model_reset();
    m_pm_sts = 16'h0100; m_pm_en = 0; m_pm_ctl = 0; m_gp_sts = 0; m_gp_en = 0;
    m_glb_sts = 0; m_glb_en = 0; m_dev_sts = 0; m_glb_ctl = 0; m_dev_ctl = 0;
    m_sci = 0; m_susp = 0;
  endtask

  task automatic model_update();
    logic [15:0] nctl;
    m_sci = |(m_pm_sts & m_pm_en & 16'h0521);
    nctl = 16'(rw(32'(m_pm_ctl), 32'h3C07, 6'h04, 2));
    m_susp = lhit(6'h04, 2) && nctl[13];
    m_pm_sts  = 16'(w1c(32'(m_pm_sts), 32'h8D31, 6'h00, 2, 32'(pm_ev | {15'h0, ovf})));
    m_gp_sts  = 16'(w1c(32'(m_gp_sts), 32'h0F81, 6'h0C, 2, 32'(gp_ev)));
    m_glb_sts = 16'(w1c(32'(m_glb_sts), 32'h0DF7, 6'h18, 2, 32'(glb_ev)));
    m_dev_sts = w1c(m_dev_sts, 32'h3FFF0FFF, 6'h1C, 4, dev_ev);
    m_pm_en   = 16'(rw(32'(m_pm_en), 32'h0521, 6'h02, 2));
    m_pm_ctl  = nctl;
    m_gp_en   = 16'(rw(32'(m_gp_en), 32'h0F01, 6'h0E, 2));
    m_glb_en  = 16'(rw(32'(m_glb_en), 32'h8D1F, 6'h20, 2));
    m_glb_ctl = rw(m_glb_ctl, 32'h0700FF07, 6'h28, 4);
    m_dev_ctl = rw(m_dev_ctl, 32'h0FFFFFFF, 6'h2C, 4);
  endtask

  // inputs are driven just after a negedge; check then clock
  task automatic tick();
    #1;
    if (re) chk(rtag_full(addr), 32'(rdata), 32'(mread(addr)));
    else    chk("R11", 32'(rdata), 32'h0);
    chk("R7", 32'(intx | irq9), 32'(m_sci));
    chk("R8", 32'({intx, irq9}), 32'({m_sci & route, m_sci & ~route}));
    chk("R10 req", 32'(sreq), 32'(m_susp));
    if (m_susp) chk("R10 type", 32'(stype), 32'(m_pm_ctl[12:10]));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    we = 0; re = 1; wd = 0; pm_ev = 0; gp_ev = 0; glb_ev = 0; dev_ev = 0; ovf = 0;
  endtask
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    idle(); we = 1; addr = a; wd = d; tick();
  endtask
  task automatic rd(input logic [5:0] a);
    idle(); addr = a; tick();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state and R2 power-up bit, R6 summary, R5 forced bit
    rd(6'h01); rd(6'h00); rd(6'h18); rd(6'h1F); rd(6'h05);
    chk("R2 reset", 32'(m_pm_sts), 32'h0100);
    idle(); re = 0; addr = 6'h00; tick();

    // R3 masked writes, R1 unmapped
    wr(6'h02, 8'hFF); wr(6'h03, 8'hFF); rd(6'h02); rd(6'h03);
    wr(6'h08, 8'hAA); rd(6'h08); wr(6'h3F, 8'h55); rd(6'h3F);
    // R7/R8 power button pending and enabled -> interrupt, both routes
    route = 1; rd(6'h00); rd(6'h00);
    route = 0; rd(6'h00);
    // R2 clear power button; interrupt drops one cycle later
    wr(6'h01, 8'h01); rd(6'h00); rd(6'h00);
    // R9 overflow pulse
    idle(); ovf = 1; tick(); rd(6'h00); rd(6'h00);
    // R2 set wins over clear
    idle(); we = 1; addr = 6'h00; wd = 8'h01; ovf = 1; tick(); rd(6'h00);
    wr(6'h00, 8'h01); wr(6'h02, 8'h00); wr(6'h03, 8'h00); rd(6'h00);
    // R10 suspend type 1 and type 0
    wr(6'h05, 8'h24); rd(6'h05);
    wr(6'h04, 8'h07); rd(6'h04);
    wr(6'h05, 8'h20); rd(6'h05); wr(6'h05, 8'h00);
    // R4/R6 status summary
    idle(); gp_ev = 16'h0080; dev_ev = 32'h0000_0100; glb_ev = 16'hFFFF; smm = 1; tick();
    rd(6'h18); rd(6'h19); rd(6'h0C); rd(6'h1D);
    wr(6'h18, 8'hFF); wr(6'h19, 8'hFF); rd(6'h18); rd(6'h19); smm = 0;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      we = ($urandom % 2) == 0;
      re = ($urandom % 8) != 0;
      addr = 6'($urandom % 64);
      wd = 8'($urandom);
      if ($urandom % 6 == 0) pm_ev = 16'(1 << ($urandom % 16));
      if ($urandom % 9 == 0) gp_ev = 16'(1 << ($urandom % 16));
      if ($urandom % 9 == 0) glb_ev = 16'(1 << ($urandom % 16));
      if ($urandom % 9 == 0) dev_ev = 32'(1 << ($urandom % 32));
      ovf = ($urandom % 10) == 0;
      smm = $urandom % 2;
      route = $urandom % 2;
      tick();
    end
    idle(); tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule